// File: doc/BRIEF.md
# E3 Frame Alignment Synchronizer

This block receives a decoded serial bit stream, one bit per clock in which a bit-valid input is high, and locates the 10-bit alignment word that opens every 1536-bit frame. It reports whether the stream is in frame. It also produces two strobes that are aligned to the incoming bits: a start-of-frame pulse on the first bit of each frame, and a payload enable that is high on the bits after the 12-bit overhead.

When alignment is lost, the block starts a fresh search. During the search the strobes keep the timing of the last known frame position. On re-acquisition the strobes jump to the new position. A sticky realignment flag records that the frame position moved, and a clear input resets that flag.

Top module: `e3_frame_sync`

## Requirements
- R1: After reset `out_of_frame` is 1 and `realigned` is 0. The strobes free-run from reset with no relation to the data: `frame_start` is high on the first valid bit after reset and on every 1536th valid bit after it.
- R2: In a cycle with `bit_vld` low, `frame_start` and `payload_en` are low and nothing advances. A bit preceded by any number of idle cycles is treated exactly like one with none.
- R3: The alignment word is 1111010000, received leftmost bit first, and it occupies frame bits 0 to 9. Alignment is declared when the word is seen at one bit position in 3 consecutive frames. `out_of_frame` falls after the clock edge that takes the last bit of the third word.
- R4: While aligned, `frame_start` is high on the first bit of the alignment word. `payload_en` is low on frame bits 0 to 11 and high on bits 12 to 1535.
- R5: During a search, one errored word at the candidate position discards the candidate. Three further consecutive good frames are then needed for alignment.
- R6: While aligned, the word is checked at frame bits 0 to 9. `out_of_frame` rises after the edge that takes the last bit of the 4th consecutive errored word. Three errored words followed by a good one keep the block in frame.
- R7: While `out_of_frame` is high, `frame_start` and `payload_en` keep the frame timing that was in force when alignment was lost.
- R8: `realigned` sets when alignment is re-acquired at a bit position different from the previous alignment. It does not set on the first acquisition after reset. It does not set when the word is re-acquired at the previous position.
- R9: `realigned` stays set until a cycle with `clr_realign` high clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Decoded serial data bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit |
| clr_realign | input | 1 | Clears the sticky realignment flag |
| out_of_frame | output | 1 | High while no frame alignment is held |
| frame_start | output | 1 | High on the first bit of each frame |
| payload_en | output | 1 | High on payload bits of each frame |
| realigned | output | 1 | Sticky flag: alignment moved to a new position |

## Verification
The payload is random but never holds four ones in a row, so the alignment word can occur only where the bench places it. Every acquisition or loss instant is therefore known in advance. Directed frame sequences are used to separate the different counting rules:
- Three clean frames show the acquisition count.
- Three errored frames followed by a good one show that the loss count needs consecutive errors.
- A broken run during a search shows that the candidate is dropped.
- A repeated loss at the same position, compared with a 37-bit slip, separates a re-acquisition that must not raise the realignment flag from one that must.

Random idle gaps between bits and a tail of randomly errored frames check that `bit_vld` gating never shifts the strobes.

// File: rtl/e3fs_pkg.sv
package e3fs_pkg;

  // Next position in a ring of len positions.
  function automatic int unsigned ring_next(int unsigned cur, int unsigned len);
    return (cur + 1 >= len) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/e3fs_word_det.sv
module e3fs_word_det #(
  parameter int unsigned          WORD_BITS = 10,
  parameter logic [WORD_BITS-1:0] PATTERN   = 10'b1111010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic word_hit
);
  logic [WORD_BITS-1:0] hist_q;
  logic [WORD_BITS-1:0] window;

  // Window that includes the bit on the input right now.
  assign window   = {hist_q[WORD_BITS-2:0], bit_in};
  assign word_hit = bit_vld && (window == PATTERN);

  always_ff @(posedge clk) begin
    if (!rst_n)       hist_q <= '0;
    else if (bit_vld) hist_q <= window;
  end
endmodule

// File: rtl/e3fs_frame_ctr.sv
module e3fs_frame_ctr
  import e3fs_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  parameter int unsigned OH_BITS    = 12,
  parameter int unsigned PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          load,
  input  logic [PW-1:0] load_pos,
  output logic [PW-1:0] pos,
  output logic          frame_start,
  output logic          payload_en
);
  localparam logic [PW-1:0] OH_POS   = PW'(OH_BITS);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);

  assign frame_start = bit_vld && (pos == '0);
  assign payload_en  = bit_vld && (pos >= OH_POS);

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (bit_vld) pos <= load ? load_pos : PW'(ring_next(int'(pos), FRAME_BITS));
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(pos));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !load && pos == LAST_POS) |=> pos == '0);
  p_start_not_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !payload_en);
endmodule

// File: rtl/e3fs_hunt.sv
module e3fs_hunt
  import e3fs_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  parameter int unsigned WORD_BITS  = 10,
  parameter int unsigned ACQ_HITS   = 3,
  parameter int unsigned PW         = $clog2(FRAME_BITS),
  parameter int unsigned HW         = $clog2(ACQ_HITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          bit_vld,
  input  logic          word_hit,
  output logic          acq,
  output logic [PW-1:0] cand_pos
);
  localparam logic [PW-1:0] CHECK_POS = PW'(WORD_BITS - 1);
  localparam logic [PW-1:0] AFTER_POS = PW'(WORD_BITS);
  localparam logic [HW-1:0] LAST_HIT  = HW'(ACQ_HITS - 1);

  logic          cand_vld;
  logic [HW-1:0] hits;
  logic          check_pt;

  assign check_pt = enable && bit_vld && cand_vld && (cand_pos == CHECK_POS);
  assign acq      = check_pt && word_hit && (hits == LAST_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cand_vld <= 1'b0;
      hits     <= '0;
      cand_pos <= '0;
    end else if (bit_vld) begin
      if (cand_vld) begin
        cand_pos <= PW'(ring_next(int'(cand_pos), FRAME_BITS));
        if (cand_pos == CHECK_POS) begin
          if (word_hit && hits != LAST_HIT) hits <= hits + 1'b1;
          else                              cand_vld <= 1'b0;
        end
      end else if (word_hit) begin
        cand_vld <= 1'b1;
        cand_pos <= AFTER_POS;
        hits     <= HW'(1);
      end
    end
  end

  p_hits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hits <= LAST_HIT);
  p_drop_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (check_pt && !word_hit) |=> !cand_vld);
endmodule

// File: rtl/e3_frame_sync.sv
module e3_frame_sync #(
  parameter int unsigned          FRAME_BITS  = 1536,
  parameter int unsigned          FAW_BITS    = 10,
  parameter logic [FAW_BITS-1:0]  FAW_WORD    = 10'b1111010000,
  parameter int unsigned          OH_BITS     = 12,
  parameter int unsigned          ACQ_HITS    = 3,
  parameter int unsigned          LOSS_MISSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic clr_realign,
  output logic out_of_frame,
  output logic frame_start,
  output logic payload_en,
  output logic realigned
);
  localparam int unsigned   PW         = $clog2(FRAME_BITS);
  localparam int unsigned   MW         = $clog2(LOSS_MISSES);
  localparam logic [PW-1:0] CHECK_POS  = PW'(FAW_BITS - 1);
  localparam logic [PW-1:0] AFTER_POS  = PW'(FAW_BITS);
  localparam logic [MW-1:0] LAST_MISS  = MW'(LOSS_MISSES - 1);

  logic          word_hit;
  logic          acq;
  logic [PW-1:0] cand_pos;
  logic [PW-1:0] pos;
  logic [MW-1:0] miss_cnt;
  logic          had_lock;
  logic          in_check;
  logic          lose;
  logic          moved;

  e3fs_word_det #(.WORD_BITS(FAW_BITS), .PATTERN(FAW_WORD)) u_det (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .word_hit(word_hit)
  );

  e3fs_hunt #(.FRAME_BITS(FRAME_BITS), .WORD_BITS(FAW_BITS), .ACQ_HITS(ACQ_HITS), .PW(PW)) u_hunt (
    .clk(clk), .rst_n(rst_n), .enable(out_of_frame), .bit_vld(bit_vld),
    .word_hit(word_hit), .acq(acq), .cand_pos(cand_pos)
  );

  e3fs_frame_ctr #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .load(acq), .load_pos(AFTER_POS),
    .pos(pos), .frame_start(frame_start), .payload_en(payload_en)
  );

  // Alignment-word check while in frame, and the events it produces.
  assign in_check = !out_of_frame && bit_vld && (pos == CHECK_POS);
  assign lose     = in_check && !word_hit && (miss_cnt == LAST_MISS);
  assign moved    = acq && had_lock && (cand_pos != pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_of_frame <= 1'b1;
      miss_cnt     <= '0;
      had_lock     <= 1'b0;
      realigned    <= 1'b0;
    end else begin
      if (acq)       out_of_frame <= 1'b0;
      else if (lose) out_of_frame <= 1'b1;

      if (acq || lose) miss_cnt <= '0;
      else if (in_check) miss_cnt <= word_hit ? '0 : miss_cnt + 1'b1;

      if (acq) had_lock <= 1'b1;

      if (moved)            realigned <= 1'b1;
      else if (clr_realign) realigned <= 1'b0;
    end
  end

  p_acq_in_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acq |-> out_of_frame);
  p_lock_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_of_frame) |-> $past(acq));
  p_loss_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_of_frame) |-> ($past(miss_cnt) == LAST_MISS && $past(bit_vld)));
  p_realign_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(realigned) |-> ($past(acq) && $past(had_lock)));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (realigned && !clr_realign) |=> realigned);
endmodule

// File: tb/tb_e3_frame_sync.sv
module tb_e3_frame_sync;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 1536;
  localparam int WB         = 10;
  localparam int OH         = 12;
  localparam logic [9:0] FAW = 10'b1111010000;

  logic clk, rst_n, bit_in, bit_vld, clr_realign;
  logic out_of_frame, frame_start, payload_en, realigned;

  e3_frame_sync dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .clr_realign(clr_realign), .out_of_frame(out_of_frame),
    .frame_start(frame_start), .payload_en(payload_en), .realigned(realigned)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Expected state, kept in terms of frames and bit positions.
  bit exp_oof = 1, exp_chg = 0, had = 0;
  int exp_pos = 0, run = 0, miss = 0, ones_run = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic send_bit(bit b, bit word_end, bit good);
    int nxt;
    string tag;
    @(negedge clk);
    if ($urandom_range(3) == 0) begin
      bit_vld = 0; bit_in = 1'($urandom);
      #1;
      check_eq("R2", "idle frame_start", frame_start, 0);
      check_eq("R2", "idle payload_en", payload_en, 0);
      @(negedge clk);
    end
    bit_in = b; bit_vld = 1;
    #1;
    tag = exp_oof ? (had ? "R7" : "R1") : "R4";
    check_eq(tag, "frame_start", frame_start, int'(exp_pos == 0));
    check_eq(tag, "payload_en", payload_en, int'(exp_pos >= OH));
    nxt = (exp_pos + 1) % FRAME;
    if (exp_oof) begin
      if (word_end) begin
        if (good) begin
          run++;
          if (run == 3) begin
            exp_oof = 0;
            if (had && exp_pos != WB - 1) exp_chg = 1;
            had = 1; nxt = WB; run = 0; miss = 0;
          end
        end else run = 0;
      end
    end else if (exp_pos == WB - 1) begin
      if (word_end && good) miss = 0;
      else begin
        miss++;
        if (miss == 4) begin exp_oof = 1; miss = 0; run = 0; end
      end
    end
    exp_pos = nxt;
    ones_run = b ? ones_run + 1 : 0;
    @(posedge clk);
    #1;
    check_eq("R3,R5,R6", "out_of_frame", out_of_frame, int'(exp_oof));
    check_eq("R8", "realigned", realigned, int'(exp_chg));
  endtask

  // Random bit that never extends a run of ones to four.
  task automatic send_junk(int n);
    for (int k = 0; k < n; k++) send_bit((ones_run >= 3) ? 1'b0 : 1'($urandom), 0, 0);
  endtask

  task automatic send_frame(bit good);
    for (int i = 0; i < WB; i++) begin
      bit b = FAW[WB-1-i];
      if (!good && i == 0) b = ~b;
      send_bit(b, i == WB - 1, good);
    end
    send_bit(0, 0, 0);
    send_bit(0, 0, 0);
    send_junk(FRAME - OH);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; bit_in = 0; bit_vld = 0; clr_realign = 0;
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1", "reset out_of_frame", out_of_frame, 1);
    check_eq("R1", "reset realigned", realigned, 0);
    check_eq("R1", "reset frame_start idle", frame_start, 0);
    @(negedge clk); rst_n = 1;

    send_junk(100);                         // R1 free-running strobes
    repeat (3) send_frame(1);               // R3 acquisition
    check_eq("R3", "locked after 3 words", out_of_frame, 0);
    check_eq("R8", "no flag on first lock", realigned, 0);
    repeat (2) send_frame(1);

    repeat (3) send_frame(0); send_frame(1); // R6 interrupted errors
    repeat (3) send_frame(0); send_frame(1);
    check_eq("R6", "still in frame", out_of_frame, 0);

    repeat (4) send_frame(0);               // R6 loss
    check_eq("R6", "lost after 4", out_of_frame, 1);
    send_frame(1); send_frame(1); send_frame(0); // R5 broken run
    send_frame(1); send_frame(1);
    check_eq("R5", "not yet locked", out_of_frame, 1);
    send_frame(1);
    check_eq("R5", "locked again", out_of_frame, 0);
    check_eq("R8", "same position no flag", realigned, 0);

    send_junk(37);                          // slip while in frame
    repeat (7) send_frame(1);               // R7 hold, R8 new position
    check_eq("R8", "flag after move", realigned, 1);
    send_frame(1);
    check_eq("R9", "flag sticky", realigned, 1);

    @(negedge clk); bit_vld = 0; clr_realign = 1;
    @(posedge clk); #1;
    clr_realign = 0; exp_chg = 0;
    check_eq("R9", "flag cleared", realigned, 0);
    send_frame(1);

    for (int f = 0; f < 6; f++) send_frame($urandom_range(2) != 0);
    repeat (3) send_frame(1);
    check_eq("R3", "final lock", out_of_frame, 0);
    @(negedge clk); bit_vld = 0;
    finish_run();
  end
endmodule